// File: doc/BRIEF.md
# LED Driver Mode Sequence Detector

This block decides whether a serial constant-current LED driver is in normal operation or in fault-detection operation. The driver has no dedicated pin for this choice. Instead, the output-enable level and the latch-enable level are sampled together on every rising clock edge. Two fixed five-edge patterns of these paired levels act as commands. One pattern moves the driver from normal operation into fault detection. The other pattern moves it back.

The block keeps a sliding record of the most recent level pairs. On each edge it compares that record, including the pair sampled at that edge, with the one command that is legal in the current mode. A match flips a registered mode flag and raises a change pulse for one cycle. It also empties the record, so that samples left over from one command cannot help complete another. The shift register, latch, current outputs and fault sensing are outside this block. Downstream logic uses the mode flag to decide how the serial data path behaves.

Top module: `led_mode_seq_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `det_mode` to 0 (normal) and `mode_changed` to 0, and empties the sample record. Pairs sampled before the reset cannot contribute to a later match.
- R2: In normal mode, the entry command switches `det_mode` to 1. Over five consecutive edges, the command is oe_lvl = 1,0,1,1,1 together with le_lvl = 0,0,0,1,0. `det_mode` is 1 in the cycle that follows the fifth edge, so the sixth edge already samples in detection mode.
- R3: `mode_changed` is 1 for exactly one cycle, and only in the cycle right after the edge at which `det_mode` changed value. At all other times it is 0.
- R4: In detection mode, the exit command switches `det_mode` back to 0 after its fifth edge. The exit command is oe_lvl = 1,0,1,1,1 with le_lvl held at 0 for all five edges.
- R5: A command that is not legal in the current mode has no effect. An exit command in normal mode and an entry command in detection mode both leave `det_mode` unchanged and give no pulse. A repeated identical command therefore does nothing the second time.
- R6: After a match the sample record is cleared. The next command needs five fresh pairs, and pairs from the completed command never count toward it.
- R7: A command is recognised wherever it starts. Arbitrary pairs sampled before it do not prevent a match of its five edges.
- R8: Two mode changes are always at least five edges apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| oe_lvl | input | 1 | Output-enable line level sampled at each edge |
| le_lvl | input | 1 | Latch-enable line level sampled at each edge |
| det_mode | output | 1 | Registered mode flag: 0 normal, 1 fault detection |
| mode_changed | output | 1 | One-cycle pulse after each mode change |

## Verification
The entry command is sent after junk pairs in normal mode. This shows that a sliding match works and that the new mode appears in the cycle after the fifth edge. Each command is also sent in the mode where it is illegal, which separates a matcher that looks only at the legal pattern from one that accepts both. Right after entry, a four-pair tail is sent that would complete an exit command if the last entry pair were still held. This tells a cleared record apart from a stale one. A reset in the middle of a command shows that partial history is discarded. A behavioural queue model is compared with both outputs on every cycle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int SEQ_LEN = 5;
  localparam int PAIR_W  = 2;
  localparam int WIN_W   = SEQ_LEN * PAIR_W;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DETECT = 1'b1
  } drv_mode_e;

  // oldest pair in the most significant bits; each pair is {oe, le}
  localparam logic [WIN_W-1:0] ENTER_PAT = 10'b10_00_10_11_10;
  localparam logic [WIN_W-1:0] LEAVE_PAT = 10'b10_00_10_10_10;

  function automatic logic [PAIR_W-1:0] pack_pair(input logic oe, input logic le);
    return {oe, le};
  endfunction

  function automatic logic [WIN_W-1:0] legal_pattern(input drv_mode_e m);
    return (m == MODE_NORMAL) ? ENTER_PAT : LEAVE_PAT;
  endfunction

endpackage

// File: rtl/mseq_history.sv
module mseq_history #(
  parameter int PAIR_W = 2,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WIN_W = (DEPTH + 1) * PAIR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [PAIR_W-1:0] cur_pair,
  output logic [WIN_W-1:0]  window,
  output logic [CNT_W-1:0]  fill
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PAIR_W-1:0] stage [DEPTH];

  // stage[0] holds the newest stored pair, stage[DEPTH-1] the oldest
  always_ff @(posedge clk) begin
    if (rst || clear) stage[0] <= '0;
    else              stage[0] <= cur_pair;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst || clear) stage[g] <= '0;
      else              stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  fill <= '0;
    else if (fill != FULL) fill <= fill + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_win
    assign window[(g+1)*PAIR_W +: PAIR_W] = stage[g];
  end
  assign window[PAIR_W-1:0] = cur_pair;

endmodule

// File: rtl/mseq_match.sv
module mseq_match
  import mseq_pkg::*;
#(
  parameter int DEPTH = SEQ_LEN - 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  drv_mode_e        mode,
  input  logic [WIN_W-1:0] window,
  input  logic [CNT_W-1:0] fill,
  output logic             hit
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic window_full;
  logic pat_equal;

  assign window_full = (fill == FULL);
  assign pat_equal   = (window == legal_pattern(mode));
  assign hit         = window_full && pat_equal;

endmodule

// File: rtl/mseq_mode.sv
module mseq_mode
  import mseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  output drv_mode_e mode,
  output logic      changed
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_NORMAL;
      changed <= 1'b0;
    end else begin
      changed <= hit;
      if (hit) mode <= (mode == MODE_NORMAL) ? MODE_DETECT : MODE_NORMAL;
    end
  end

endmodule

// File: rtl/led_mode_seq_detector.sv
module led_mode_seq_detector
  import mseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oe_lvl,
  input  logic le_lvl,
  output logic det_mode,
  output logic mode_changed
);

  localparam int DEPTH = SEQ_LEN - 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PAIR_W-1:0] cur_pair;
  logic [WIN_W-1:0]  window;
  logic [CNT_W-1:0]  hist_fill;
  logic              seq_hit;
  drv_mode_e         mode_q;

  assign cur_pair = pack_pair(oe_lvl, le_lvl);

  mseq_history #(.PAIR_W(PAIR_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .clear    (seq_hit),
    .cur_pair (cur_pair),
    .window   (window),
    .fill     (hist_fill)
  );

  mseq_match #(.DEPTH(DEPTH)) u_match (
    .mode   (mode_q),
    .window (window),
    .fill   (hist_fill),
    .hit    (seq_hit)
  );

  mseq_mode u_mode (
    .clk     (clk),
    .rst     (rst),
    .hit     (seq_hit),
    .mode    (mode_q),
    .changed (mode_changed)
  );

  assign det_mode = (mode_q == MODE_DETECT);

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int SEQ_LEN = 5,
  localparam int CNT_W  = $clog2(SEQ_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             det_mode,
  input logic             mode_changed,
  input logic             seq_hit,
  input logic [CNT_W-1:0] hist_fill
);

  localparam int GAP_W = $clog2(SEQ_LEN + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(SEQ_LEN);

  logic             past_ok;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      gap     <= GAP_MAX;
    end else begin
      past_ok <= 1'b1;
      if (mode_changed)      gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + 1'b1;
    end
  end

  // R1: the first cycle after reset is quiet and in normal mode
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!det_mode && !mode_changed && hist_fill == '0));

  // R3: a flag change is always accompanied by the pulse
  a_r3_pulse_on_flip: assert property (@(posedge clk) disable iff (rst)
    (past_ok && det_mode != $past(det_mode)) |-> mode_changed);

  // R3: the pulse never appears without a flag change
  a_r3_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    (past_ok && mode_changed) |-> (det_mode != $past(det_mode)));

  // R2 and R4: a recognised command flips the flag at the next edge
  a_r2_r4_hit_flips: assert property (@(posedge clk) disable iff (rst)
    seq_hit |=> (det_mode != $past(det_mode)));

  // R6: the record is empty right after a match
  a_r6_clear_after_hit: assert property (@(posedge clk) disable iff (rst)
    seq_hit |=> (hist_fill == '0));

  // R8: mode changes stay at least SEQ_LEN edges apart
  a_r8_min_gap: assert property (@(posedge clk) disable iff (rst)
    mode_changed |-> (gap >= GAP_W'(SEQ_LEN - 1)));

endmodule

bind led_mode_seq_detector mseq_checker #(.SEQ_LEN(mseq_pkg::SEQ_LEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .det_mode     (det_mode),
  .mode_changed (mode_changed),
  .seq_hit      (seq_hit),
  .hist_fill    (hist_fill)
);

// File: tb/led_mode_seq_detector_tb.sv
module led_mode_seq_detector_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_lvl = 1'b1;
  logic le_lvl = 1'b0;
  logic det_mode;
  logic mode_changed;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  led_mode_seq_detector u_dut (
    .clk          (clk),
    .rst          (rst),
    .oe_lvl       (oe_lvl),
    .le_lvl       (le_lvl),
    .det_mode     (det_mode),
    .mode_changed (mode_changed)
  );

  // behavioural reference: queue of recent pairs, encoded oe*2+le
  int ref_q[$];
  int ref_mode = 0;
  int ref_pulse = 0;
  int enter_seq[5] = '{2, 0, 2, 3, 2};
  int leave_seq[5] = '{2, 0, 2, 2, 2};

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ref_q.delete();
      ref_mode = 0;
      ref_pulse = 0;
    end else begin
      bit same;
      ref_q.push_back(oe_lvl * 2 + le_lvl);
      if (ref_q.size() > 5) void'(ref_q.pop_front());
      ref_pulse = 0;
      if (ref_q.size() == 5) begin
        same = 1'b1;
        for (int i = 0; i < 5; i++)
          if (ref_q[i] != (ref_mode == 0 ? enter_seq[i] : leave_seq[i])) same = 1'b0;
        if (same) begin
          ref_mode = 1 - ref_mode;
          ref_pulse = 1;
          ref_q.delete();
        end
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model (R2 R3 R4 R5 R6 R7)
  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      check("R2/R4 model mode", int'(det_mode), ref_mode);
      check("R3 model pulse", int'(mode_changed), ref_pulse);
    end
  end

  task automatic step(input logic o, input logic l);
    oe_lvl = o;
    le_lvl = l;
    @(negedge clk);
  endtask

  task automatic send_enter();
    step(1, 0); step(0, 0); step(1, 0); step(1, 1); step(1, 0);
  endtask

  task automatic send_leave();
    step(1, 0); step(0, 0); step(1, 0); step(1, 0); step(1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mode", int'(det_mode), 0);
    check("R1 reset pulse", int'(mode_changed), 0);

    // R5: exit command in normal mode is ignored
    send_leave();
    check("R5 exit in normal ignored", int'(det_mode), 0);

    // R7: junk before entry, R2 entry, R3 pulse
    step(1, 1); step(0, 1); step(0, 0);
    send_enter();
    check("R2 entered detection", int'(det_mode), 1);
    check("R3 pulse on entry", int'(mode_changed), 1);
    check("R7 sliding match", int'(det_mode), 1);

    // R6: stale last entry pair must not complete an exit
    step(0, 0);
    check("R3 pulse one cycle", int'(mode_changed), 0);
    step(1, 0); step(1, 0); step(1, 0);
    check("R6 no overlap exit", int'(det_mode), 1);
    check("R8 no quick change", int'(mode_changed), 0);

    // R5: entry in detection mode ignored
    send_enter();
    check("R5 entry in detection ignored", int'(det_mode), 1);
    check("R5 no pulse", int'(mode_changed), 0);

    // R4: exit returns to normal
    send_leave();
    check("R4 back to normal", int'(det_mode), 0);
    check("R3 pulse on exit", int'(mode_changed), 1);

    // R5: repeated exit has no second effect
    send_leave();
    check("R5 repeated exit", int'(det_mode), 0);

    // R1: reset mid command discards partial history
    step(1, 0); step(0, 0); step(1, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1, 1); step(1, 0);
    check("R1 partial history dropped", int'(det_mode), 0);
    send_enter();
    check("R1 entry after reset", int'(det_mode), 1);
    step(1, 0);
    step(1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule